// File: doc/BRIEF.md
# Local Task Priority Interrupt Filter

This block sits beside one processor core and screens the interrupt messages addressed to it. Each message carries an 8-bit vector. The upper four bits of the vector form its priority class, so a larger vector is more urgent. Software writes a 4-bit task priority, and only interrupts whose class is strictly above the current floor are shown to the core. Vectors 0 to 31 belong to the architecture and are never accepted from a message.

Accepted vectors are kept in a 256-entry pending set. The highest pending vector that clears the floor is presented on `irq`/`irq_vector`. When the core acknowledges, that vector leaves the pending set and enters an in-service set. While it is in service, its class raises the floor. An end-of-interrupt retires the highest in-service vector. The vector travels with the message, so the core never has to query the source.

Top module: `task_prio_filter`

## Requirements
- R1: After reset `irq` and `bad_vector_seen` are 0. While `irq` is 0, `irq_vector` reads 0.
- R2: The class of a vector is its bits [7:4]. With nothing in service, a pending vector is offered only when its class is strictly greater than the task priority, which resets to 0.
- R3: A message with a vector below 32 is dropped and sets `bad_vector_seen`, which stays 1 until reset. Vector 32 is accepted.
- R4: When several pending vectors qualify, `irq_vector` shows the numerically highest.
- R5: `core_ack` while `irq` is 1 removes the offered vector from the pending set and places it in service, in the cycle after the edge.
- R6: The effective floor is the larger of the task priority and the class of the highest in-service vector. A pending vector of the same class as the in-service one is held back, and a higher class nests.
- R7: `core_eoi` clears the highest in-service vector. Pending vectors that the lowered floor now admits are offered in the next cycle.
- R8: A task priority write takes effect from the next cycle. Lowering the priority releases pending vectors that were held back.
- R9: `core_ack` while `irq` is 0 has no effect on the pending or in-service sets.
- R10: A second message for a vector that is already pending merges with the first, so a single acknowledge consumes both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | An interrupt message is present this cycle |
| msg_vector | input | 8 | Vector carried by the message |
| tpr_wr | input | 1 | Write strobe for the task priority |
| tpr_data | input | 4 | New task priority value |
| core_ack | input | 1 | Core takes the offered vector |
| core_eoi | input | 1 | Core finished the highest in-service vector |
| irq | output | 1 | Interrupt request to the core |
| irq_vector | output | 8 | Vector being offered, 0 when idle |
| bad_vector_seen | output | 1 | Sticky flag: a reserved vector arrived |

## Verification
The assertions assume that the core raises `core_ack` only when it means to take the vector being shown, and that it issues `core_eoi` only for a vector it took earlier. They also assume that inputs change only between clock edges. The stimulus drives every strobe for exactly one cycle, just after a rising edge. It acknowledges only while a request is visible, except in the scenario that checks a stray acknowledge. Each `core_eoi` pairs with an earlier acknowledge, in nesting order.

// File: rtl/tpf_pkg.sv
// Shared widths and helpers for the task priority interrupt filter.
// Assumes 8-bit vectors with the class in the top four bits.
package tpf_pkg;
    localparam int VEC_W    = 8;
    localparam int CLS_W    = 4;
    localparam int NUM_VEC  = 1 << VEC_W;
    localparam int RSVD_TOP = 32;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [CLS_W-1:0] cls_t;

    // Priority class of a vector: its most significant bits.
    function automatic cls_t vec_class(input vec_t v);
        return v[VEC_W-1 -: CLS_W];
    endfunction
endpackage

// File: rtl/tpf_msb_find.sv
// Finds the highest set bit of a vector.
// Assumes W is a power of two. idx is 0 when no bit is set.
module tpf_msb_find #(
    parameter  int W  = 256,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan upward so the last hit, the highest bit, wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tpf_intake.sv
// Screens incoming messages: reserved vectors are refused and flagged.
// Assumes a message is a one-cycle strobe with its vector.
module tpf_intake
    import tpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic msg_valid,
    input  vec_t msg_vector,
    output logic accept,
    output logic bad_q
);
    logic reserved;

    // Classify the vector against the reserved range.
    always_comb begin
        reserved = (msg_vector < vec_t'(RSVD_TOP));
        accept   = msg_valid && !reserved;
    end

    // Sticky record of any reserved-vector message.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bad_q <= 1'b0;
        else if (msg_valid && reserved)
            bad_q <= 1'b1;
    end
endmodule

// File: rtl/tpf_vector_sets.sv
// Holds the pending and in-service vector sets.
// Assumes take_vec is a pending vector and retire_vec is in service.
// A new message for a vector wins over a take of the same vector.
module tpf_vector_sets
    import tpf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  vec_t               set_vec,
    input  logic               take_en,
    input  vec_t               take_vec,
    input  logic               retire_en,
    input  vec_t               retire_vec,
    output logic [NUM_VEC-1:0] pend_q,
    output logic [NUM_VEC-1:0] insvc_q
);
    logic [NUM_VEC-1:0] pend_nxt;
    logic [NUM_VEC-1:0] insvc_nxt;

    // Next pending and in-service contents from this cycle's events.
    always_comb begin
        pend_nxt  = pend_q;
        insvc_nxt = insvc_q;
        if (take_en)   pend_nxt[take_vec]    = 1'b0;
        if (set_en)    pend_nxt[set_vec]     = 1'b1;
        if (retire_en) insvc_nxt[retire_vec] = 1'b0;
        if (take_en)   insvc_nxt[take_vec]   = 1'b1;
    end

    // State registers for both sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            insvc_q <= '0;
        end else begin
            pend_q  <= pend_nxt;
            insvc_q <= insvc_nxt;
        end
    end
endmodule

// File: rtl/tpf_gate.sv
// Compares the best pending vector with the effective floor, which is
// the larger of the task priority and the class in service.
// Assumes the inputs come from registers, so the output is glitch-free per cycle.
module tpf_gate
    import tpf_pkg::*;
(
    input  cls_t tpr,
    input  logic pend_any,
    input  vec_t pend_top,
    input  logic isr_any,
    input  vec_t isr_top,
    output logic req,
    output vec_t req_vec
);
    cls_t isr_cls;
    cls_t floor_cls;

    // Effective floor and the offer decision.
    always_comb begin
        isr_cls   = isr_any ? vec_class(isr_top) : '0;
        floor_cls = (isr_cls > tpr) ? isr_cls : tpr;
        req       = pend_any && (vec_class(pend_top) > floor_cls);
        req_vec   = req ? pend_top : '0;
    end
endmodule

// File: rtl/task_prio_filter.sv
// Per-core interrupt filter with task priority gating and nesting.
// Assumes the core acks only a shown vector and retires in nesting order.
module task_prio_filter
    import tpf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  msg_valid,
    input  logic [VEC_W-1:0]      msg_vector,
    input  logic                  tpr_wr,
    input  logic [CLS_W-1:0]      tpr_data,
    input  logic                  core_ack,
    input  logic                  core_eoi,
    output logic                  irq,
    output logic [VEC_W-1:0]      irq_vector,
    output logic                  bad_vector_seen
);
    cls_t               tpr_q;
    logic               accept;
    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] insvc_q;
    logic               pend_any;
    logic               isr_any;
    vec_t               pend_top;
    vec_t               isr_top;
    logic               take_en;
    logic               retire_en;

    // Task priority register, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tpr_q <= '0;
        else if (tpr_wr)
            tpr_q <= tpr_data;
    end

    // Acknowledge counts only while a request is shown. EOI only with something in service.
    always_comb begin
        take_en   = core_ack && irq;
        retire_en = core_eoi && isr_any;
    end

    tpf_intake u_intake (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_valid  (msg_valid),
        .msg_vector (msg_vector),
        .accept     (accept),
        .bad_q      (bad_vector_seen)
    );

    tpf_vector_sets u_sets (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (accept),
        .set_vec    (msg_vector),
        .take_en    (take_en),
        .take_vec   (irq_vector),
        .retire_en  (retire_en),
        .retire_vec (isr_top),
        .pend_q     (pend_q),
        .insvc_q    (insvc_q)
    );

    // One priority finder for each of the two sets.
    for (genvar g = 0; g < 2; g++) begin : g_find
        logic [NUM_VEC-1:0] src;
        logic               hit;
        logic [VEC_W-1:0]   top;
        assign src = (g == 0) ? pend_q : insvc_q;
        tpf_msb_find #(.W(NUM_VEC)) u_find (
            .bits (src),
            .any  (hit),
            .idx  (top)
        );
    end

    assign pend_any = g_find[0].hit;
    assign pend_top = g_find[0].top;
    assign isr_any  = g_find[1].hit;
    assign isr_top  = g_find[1].top;

    tpf_gate u_gate (
        .tpr      (tpr_q),
        .pend_any (pend_any),
        .pend_top (pend_top),
        .isr_any  (isr_any),
        .isr_top  (isr_top),
        .req      (irq),
        .req_vec  (irq_vector)
    );
endmodule

// File: rtl/tpf_checker.sv
// Temporal checks for task_prio_filter, bound into the top module.
// Assumes inputs change only between clock edges.
module tpf_checker
    import tpf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic [VEC_W-1:0] msg_vector,
    input logic             tpr_wr,
    input logic [CLS_W-1:0] tpr_data,
    input logic             core_ack,
    input logic             irq,
    input logic [VEC_W-1:0] irq_vector,
    input logic             bad_vector_seen,
    input logic [CLS_W-1:0] tpr_q
);
    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> irq_vector == '0); // R1
    AST_OFFER_ABOVE_TPR: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> vec_class(irq_vector) > tpr_q); // R2
    AST_OFFER_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_vector >= VEC_W'(RSVD_TOP)); // R3
    AST_RESERVED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_vector < VEC_W'(RSVD_TOP)) |=> bad_vector_seen); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bad_vector_seen |=> bad_vector_seen); // R3
    AST_ACK_RAISES_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack && irq) |=> (!irq || vec_class(irq_vector) > vec_class($past(irq_vector)))); // R6
    AST_TPR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_wr |=> tpr_q == $past(tpr_data)); // R8
endmodule

bind task_prio_filter tpf_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .msg_valid       (msg_valid),
    .msg_vector      (msg_vector),
    .tpr_wr          (tpr_wr),
    .tpr_data        (tpr_data),
    .core_ack        (core_ack),
    .irq             (irq),
    .irq_vector      (irq_vector),
    .bad_vector_seen (bad_vector_seen),
    .tpr_q           (tpr_q)
);

// File: tb/tb_task_prio_filter.sv
`timescale 1ns/1ps
module tb_task_prio_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       msg_valid = 1'b0;
    logic [7:0] msg_vector = '0;
    logic       tpr_wr = 1'b0;
    logic [3:0] tpr_data = '0;
    logic       core_ack = 1'b0;
    logic       core_eoi = 1'b0;
    logic       irq;
    logic [7:0] irq_vector;
    logic       bad_vector_seen;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    task_prio_filter dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .msg_valid       (msg_valid),
        .msg_vector      (msg_vector),
        .tpr_wr          (tpr_wr),
        .tpr_data        (tpr_data),
        .core_ack        (core_ack),
        .core_eoi        (core_eoi),
        .irq             (irq),
        .irq_vector      (irq_vector),
        .bad_vector_seen (bad_vector_seen)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input bit e_irq, input int e_vec);
        chk(irq == e_irq, req, int'(irq), int'(e_irq));
        chk(irq_vector == 8'(e_vec), req, int'(irq_vector), e_vec);
    endtask

    task automatic send(input int v);
        msg_valid = 1'b1; msg_vector = 8'(v); step(); msg_valid = 1'b0;
    endtask
    task automatic ack();
        core_ack = 1'b1; step(); core_ack = 1'b0;
    endtask
    task automatic eoi();
        core_eoi = 1'b1; step(); core_eoi = 1'b0;
    endtask
    task automatic set_tpr(input int p);
        tpr_wr = 1'b1; tpr_data = 4'(p); step(); tpr_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk_out("R1", 1'b0, 0);
        chk(bad_vector_seen == 1'b0, "R1", int'(bad_vector_seen), 0);
    endtask

    task automatic t_basic();
        send('h45); chk_out("R2", 1'b1, 'h45);
        ack();      chk_out("R5", 1'b0, 0);
        eoi();      chk_out("R7", 1'b0, 0);
    endtask

    task automatic t_tpr_gate();
        set_tpr(4);
        send('h4A); chk_out("R2 class equal tpr held", 1'b0, 0);
        send('h50); chk_out("R2", 1'b1, 'h50);
        ack();      chk_out("R6", 1'b0, 0);
        eoi();      chk_out("R2", 1'b0, 0);
        set_tpr(3); chk_out("R8", 1'b1, 'h4A);
        ack(); eoi();
        set_tpr(0); chk_out("R8", 1'b0, 0);
    endtask

    task automatic t_reserved();
        send('h1F); chk_out("R3", 1'b0, 0);
        chk(bad_vector_seen == 1'b1, "R3", int'(bad_vector_seen), 1);
        send('h20); chk_out("R3 boundary", 1'b1, 'h20);
        ack(); eoi();
        chk(bad_vector_seen == 1'b1, "R3 sticky", int'(bad_vector_seen), 1);
    endtask

    task automatic t_nesting();
        send('h61); chk_out("R4", 1'b1, 'h61);
        send('h63); chk_out("R4", 1'b1, 'h63);
        ack();      chk_out("R6 same class held", 1'b0, 0);
        send('h70); chk_out("R6 nests", 1'b1, 'h70);
        ack();      chk_out("R5", 1'b0, 0);
        eoi();      chk_out("R7 floor still 6", 1'b0, 0);
        eoi();      chk_out("R7", 1'b1, 'h61);
        ack(); eoi(); chk_out("R7", 1'b0, 0);
    endtask

    task automatic t_stray_ack();
        set_tpr(9);
        send('h85); chk_out("R9", 1'b0, 0);
        ack();
        set_tpr(0); chk_out("R9", 1'b1, 'h85);
        ack(); chk_out("R9", 1'b0, 0);
        eoi();
    endtask

    task automatic t_duplicate();
        send('hA0); send('hA0); chk_out("R10", 1'b1, 'hA0);
        ack();      chk_out("R10", 1'b0, 0);
        eoi();      chk_out("R10", 1'b0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_tpr_gate();
        t_reserved();
        t_nesting();
        t_stray_ack();
        t_duplicate();
        finish_run();
    end

    initial begin
        #(5 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end
endmodule